// File: doc/BRIEF.md
# Dual-Modulus Prescaler Swallow Controller

This block drives an external prescaler that divides by either P+1 or P, and is clocked by that prescaler's output. Two down-counters, a swallow counter loaded with A and a main counter loaded with M, set the length of one count cycle to M prescaler output clocks. The modulus-control output stays low for the first A of those clocks, so the prescaler divides by P+1. It is high for the remaining M−A clocks, so the prescaler divides by P. One count cycle therefore spans M·P + A input cycles of the prescaler.

At the end of every count cycle the block raises a one-clock tick for the phase detector. On the same edge that ends the tick, both counters reload. A and M are taken from the inputs only on that reload edge, so a channel change never disturbs a cycle already under way. The reset is active low. It takes effect asynchronously and is released through a two-stage synchronizer.

Top module: `pswallow_ctl`

## Requirements
- R1: While reset is asserted, `mod_ctl` and `cyc_tick` are low, and asserting reset forces them low at once. The third rising edge of `clk_pre` after `rst_n` is released starts a count cycle and samples A and M; the clock period after that edge is period 0.
- R2: With A > 0, `mod_ctl` is low in periods 0 to A−1 of every count cycle.
- R3: `mod_ctl` is high from period A up to period M−1, the last period of the cycle.
- R4: With A = 0, `mod_ctl` is high from period 0 and stays high through every cycle.
- R5: `cyc_tick` is high only in period M−1, for one clock. The edge that ends it reloads both counters and starts the next cycle, so a cycle lasts exactly M clocks.
- R6: Suppose the prescaler divides by P+1 while `mod_ctl` is low and by P while it is high. Then one count cycle spans M·P + A prescaler input cycles.
- R7: Values on `swallow_cnt` and `main_cnt` are sampled only on the reload edge. A change in the middle of a cycle first takes effect in the following cycle.
- R8: All of R2 to R6 hold across the operating range A = 0..127 and M = 8..1023 with M > A, including the extremes A = 127, M = 128 and M = 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pre | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| swallow_cnt | input | 7 | A value: number of clocks per cycle with modulus control low |
| main_cnt | input | 10 | M value: number of clocks per count cycle |
| mod_ctl | output | 1 | Modulus control: low selects P+1, high selects P |
| cyc_tick | output | 1 | One-clock tick in the last period of each count cycle |

## Verification
The end-of-cycle tick and the counter reload share one edge with the sampling of new A and M values. When A = 0, that same edge also sets the modulus control for the next cycle. To provoke this, the bench changes A and M in the middle of a cycle. It then checks that the cycle under way keeps the old pattern and that the next cycle follows the new one from its period 0. A = 0 and A = M−1 place the rise of the modulus control on the reload edge and on the last period of the cycle. Every period is compared with the expected level of the modulus control and of the tick, and the prescaler input cycles are summed over one whole cycle.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int SWL_AW = 7;
  localparam int SWL_MW = 10;
  localparam int SWL_SYNC_STAGES = 2;
endpackage

// File: rtl/swl_rst_sync.sv
module swl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/swl_dn_ctr.sv
module swl_dn_ctr #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         en_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o,
  output logic         one_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i)      cnt_d = ld_val_i;
    else if (en_i) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign one_o  = (cnt_q == W'(1));
endmodule

// File: rtl/pswallow_ctl.sv
module pswallow_ctl
  import swl_pkg::*;
#(
  parameter int AW = SWL_AW,
  parameter int MW = SWL_MW
) (
  input  logic          clk_pre,
  input  logic          rst_n,
  input  logic [AW-1:0] swallow_cnt,
  input  logic [MW-1:0] main_cnt,
  output logic          mod_ctl,
  output logic          cyc_tick
);
  logic          rst_s_n;
  logic          live_q, live_d;
  logic          mc_q, mc_d;
  logic          tk_q, tk_d;
  logic          boundary;
  logic [AW-1:0] a_cnt;
  logic [MW-1:0] m_cnt;
  logic          a_zero, a_one, m_zero, m_one;
  logic          a_en, m_en;

  swl_rst_sync #(.STAGES(SWL_SYNC_STAGES)) u_rsync (
    .clk_i (clk_pre),
    .rst_ni(rst_n),
    .rst_no(rst_s_n)
  );

  // A cycle starts on the first edge out of reset or when the main counter expires
  assign boundary = !live_q || m_zero;
  assign a_en     = !boundary && !a_zero;
  assign m_en     = !boundary;

  swl_dn_ctr #(.W(AW)) u_a_ctr (
    .clk_i   (clk_pre),
    .rst_ni  (rst_s_n),
    .ld_i    (boundary),
    .en_i    (a_en),
    .ld_val_i(swallow_cnt),
    .cnt_o   (a_cnt),
    .zero_o  (a_zero),
    .one_o   (a_one)
  );

  swl_dn_ctr #(.W(MW)) u_m_ctr (
    .clk_i   (clk_pre),
    .rst_ni  (rst_s_n),
    .ld_i    (boundary),
    .en_i    (m_en),
    .ld_val_i(main_cnt - MW'(1)),
    .cnt_o   (m_cnt),
    .zero_o  (m_zero),
    .one_o   (m_one)
  );

  always_comb begin
    live_d = 1'b1;
    if (boundary) begin
      mc_d = (swallow_cnt == '0);
      tk_d = (main_cnt == MW'(1));
    end else begin
      mc_d = a_zero || a_one;
      tk_d = m_one;
    end
  end

  always_ff @(posedge clk_pre or negedge rst_s_n) begin
    if (!rst_s_n) begin
      live_q <= 1'b0;
      mc_q   <= 1'b0;
      tk_q   <= 1'b0;
    end else begin
      live_q <= live_d;
      mc_q   <= mc_d;
      tk_q   <= tk_d;
    end
  end

  assign mod_ctl  = mc_q;
  assign cyc_tick = tk_q;
endmodule

// File: rtl/swl_chk.sv
module swl_chk #(
  parameter int AW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mc_i,
  input logic          tk_i,
  input logic [AW-1:0] a_i
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> (!mc_i && !tk_i));

  // R5
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) tk_i |=> !tk_i);

  // R3
  tick_high_mc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) tk_i |-> mc_i);

  // R2
  mc_fall_at_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(mc_i) |-> $past(tk_i));

  // R4
  reload_mc_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk_i |=> (mc_i == ($past(a_i) == '0)));
endmodule

bind pswallow_ctl swl_chk #(.AW(AW)) u_chk (
  .clk_i (clk_pre),
  .rst_ni(rst_s_n),
  .mc_i  (mod_ctl),
  .tk_i  (cyc_tick),
  .a_i   (swallow_cnt)
);

// File: tb/pswallow_ctl_tb.sv
`timescale 1ns/1ps
module pswallow_ctl_tb;
  localparam int P  = 32;
  localparam int NV = 7;
  localparam int VA [NV] = '{0, 7, 5, 127, 3, 1, 64};
  localparam int VM [NV] = '{8, 8, 20, 128, 1023, 9, 100};
  localparam int VT [NV] = '{256, 263, 645, 4223, 32739, 289, 3264};

  logic       clk_pre = 1'b0;
  logic       rst_n;
  logic [6:0] swallow_cnt;
  logic [9:0] main_cnt;
  logic       mod_ctl, cyc_tick;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk_pre = ~clk_pre;

  pswallow_ctl u_dut (
    .clk_pre    (clk_pre),
    .rst_n      (rst_n),
    .swallow_cnt(swallow_cnt),
    .main_cnt   (main_cnt),
    .mod_ctl    (mod_ctl),
    .cyc_tick   (cyc_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Check one period k of a cycle with parameters a, m
  task automatic chk_period(input int k, input int a, input int m);
    int exp_mc;
    int exp_tk;
    exp_mc = (k >= a) ? 1 : 0;
    exp_tk = (k == m - 1) ? 1 : 0;
    if (a == 0)      chk(mod_ctl == 1'(exp_mc), "R4 mod_ctl", int'(mod_ctl), exp_mc);
    else if (k < a)  chk(mod_ctl == 1'(exp_mc), "R2 mod_ctl", int'(mod_ctl), exp_mc);
    else             chk(mod_ctl == 1'(exp_mc), "R3 mod_ctl", int'(mod_ctl), exp_mc);
    chk(cyc_tick == 1'(exp_tk), "R5 cyc_tick", int'(cyc_tick), exp_tk);
  endtask

  // Hold reset, check quiet outputs, release; returns just before the load edge
  task automatic do_reset(input int a, input int m);
    @(negedge clk_pre);
    rst_n = 1'b0;
    swallow_cnt = 7'(a);
    main_cnt = 10'(m);
    repeat (3) @(negedge clk_pre);
    chk(!mod_ctl && !cyc_tick, "R1 reset outputs", int'({mod_ctl, cyc_tick}), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk_pre);
  endtask

  initial begin
    rst_n = 1'b0;
    swallow_cnt = '0;
    main_cnt = 10'd8;

    // Vector table: two cycles each, plus the input-cycle total (R6, R8)
    for (int v = 0; v < NV; v++) begin
      int tot;
      tot = 0;
      do_reset(VA[v], VM[v]);
      for (int k = 0; k < 2 * VM[v]; k++) begin
        @(posedge clk_pre);
        @(negedge clk_pre);
        chk_period(k % VM[v], VA[v], VM[v]);
        if (k < VM[v]) tot += mod_ctl ? P : P + 1;
      end
      chk(tot == VT[v], "R6 R8 total ratio", tot, VT[v]);
    end

    // R7: mid-cycle change from (4,10) to (9,12) at period 3
    do_reset(4, 10);
    for (int k = 0; k < 22; k++) begin
      @(posedge clk_pre);
      @(negedge clk_pre);
      if (k < 10) chk_period(k, 4, 10);
      else        chk_period(k - 10, 9, 12);
      if (k == 3) begin
        swallow_cnt = 7'd9;
        main_cnt = 10'd12;
      end
      if (k == 9) chk(mod_ctl == 1'b1, "R7 old cycle kept", int'(mod_ctl), 1);
      if (k == 18) chk(mod_ctl == 1'b0, "R7 new A applied", int'(mod_ctl), 0);
    end

    // R1: asynchronous reset mid-cycle while mod_ctl is high, then restart
    do_reset(2, 10);
    for (int k = 0; k < 6; k++) begin
      @(posedge clk_pre);
      @(negedge clk_pre);
      chk_period(k, 2, 10);
    end
    #0.5 rst_n = 1'b0;
    #0.5 chk(!mod_ctl && !cyc_tick, "R1 async force", int'({mod_ctl, cyc_tick}), 0);
    do_reset(2, 10);
    for (int k = 0; k < 10; k++) begin
      @(posedge clk_pre);
      @(negedge clk_pre);
      if (k == 0) chk(mod_ctl == 1'b0, "R1 restart period 0", int'(mod_ctl), 0);
      chk_period(k, 2, 10);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule